// File: doc/BRIEF.md
# Row-Indexed Dirty Bit Tracker

This block keeps the dirty status of cached blocks outside the cache tag store, grouped by DRAM row. It is a small fully associative table. Each entry holds a valid flag, a row address and a dirty vector with one bit per cache block of that row. A block address splits into a row address in its upper bits and a block index in its low log2(BLKS_PER_ROW) bits. The block index selects the vector bit.

The cache controller sends two kinds of update on one port. A mark reports a writeback into the cache and sets the block's bit. A clear reports an eviction from the cache and drops the bit. On the same cycle the port reports whether the block was dirty, so a memory writeback is issued only when needed.

Two query ports run independently of each other. One answers whether a single block is dirty. The other returns the whole dirty vector of a row in one lookup. When a mark needs a new entry and the table is full, the least recently marked entry is displaced. Its row and vector are presented for one cycle so every block it marks can be written back.

Top module: `row_dirty_tracker`

## Requirements
- R1: A block reads dirty on `q_blk_dirty` exactly when a valid entry exists for its row (address bits above the low log2(BLKS_PER_ROW) bits) and the entry's bit selected by the low bits is set. A block with no matching entry reads clean.
- R2: A row query returns, in the same cycle, `q_row_hit` and the full vector on `q_row_vec`, where bit i stands for block index i. With no entry, both are zero.
- R3: A mark (`upd_valid` with `upd_mark`=1) sets the block's bit from the next cycle on. The other bits of an existing entry are kept.
- R4: A mark to a row with no entry allocates an entry whose vector holds only that block's bit.
- R5: During any update, `upd_was_dirty` gives the block's dirty state before the update, in the same cycle. A clear (`upd_mark`=0) drops the block's bit from the next cycle on. A clear to a row with no entry changes nothing.
- R6: When an allocation displaces a valid entry, `vict_valid` is high for exactly the next cycle, with that entry's row on `vict_row` and its vector on `vict_vec`.
- R7: While any entry is invalid, an allocation takes an invalid entry and raises no victim.
- R8: The displaced entry is the valid entry least recently marked. Marks that hit or allocate refresh recency; clears and queries do not.
- R9: A clear that leaves an entry's vector all zero invalidates that entry at the same edge.
- R10: A query in the same cycle as an update to the same row returns the state from before the update.
- R11: After reset all entries are invalid, every query reads clean and `vict_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| upd_valid | input | 1 | Update request this cycle |
| upd_mark | input | 1 | 1 = mark dirty, 0 = clear |
| upd_addr | input | BLK_ADDR_W | Block address of the update |
| upd_was_dirty | output | 1 | Block was dirty before this update |
| q_blk_addr | input | BLK_ADDR_W | Block address for the single-block query |
| q_blk_dirty | output | 1 | Queried block is dirty |
| q_row | input | BLK_ADDR_W-log2(BLKS_PER_ROW) | Row address for the row query |
| q_row_hit | output | 1 | Row has a valid entry |
| q_row_vec | output | BLKS_PER_ROW | Dirty vector of the queried row |
| vict_valid | output | 1 | Displaced entry reported this cycle |
| vict_row | output | BLK_ADDR_W-log2(BLKS_PER_ROW) | Row address of the displaced entry |
| vict_vec | output | BLKS_PER_ROW | Dirty vector of the displaced entry |

## Verification
A corrupt vector bit or a stale valid flag shows at once on the two query ports. The bench reads them the cycle after each update, so a wrong bit is caught one edge after it is written. A recency error stays hidden until the table fills. It then shows as the wrong row on the victim outputs in the cycle after the displacing mark. For that reason the bench fills the table, refreshes one entry and checks two displacements in a row. A missed invalidation shows as a row hit with an empty vector, or as a victim raised while a free slot should have been used.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
  typedef enum logic {
    UPD_CLEAR = 1'b0,
    UPD_MARK  = 1'b1
  } upd_op_e;
endpackage

// File: rtl/rdt_row_cam.sv
// Associative row match over all entries; returns hit, index and vector.
module rdt_row_cam #(
  parameter int N     = 64,
  parameter int ROW_W = 20,
  parameter int VEC_W = 64,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]            ent_valid,
  input  logic [N-1:0][ROW_W-1:0] ent_row,
  input  logic [N-1:0][VEC_W-1:0] ent_vec,
  input  logic [ROW_W-1:0]        key,
  output logic [N-1:0]            match,
  output logic                    hit,
  output logic [IDX_W-1:0]        idx,
  output logic [VEC_W-1:0]        vec
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = ent_valid[i] && (ent_row[i] == key);
  end

  always_comb begin
    idx = '0;
    vec = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) begin
        idx = idx | IDX_W'(i);
        vec = vec | ent_vec[i];
      end
    end
  end

  assign hit = |match;
endmodule

// File: rtl/rdt_recency.sv
// Age ranks: 0 = most recently marked, N-1 = oldest. Free slots win first.
module rdt_recency #(
  parameter int N     = 64,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [N-1:0]     ent_valid,
  output logic [IDX_W-1:0] victim_idx
);
  logic [N-1:0][IDX_W-1:0] age_q, age_d;
  logic [IDX_W-1:0]        free_idx, old_idx;
  logic                    have_free;

  always_comb begin
    age_d = age_q;
    for (int i = 0; i < N; i++) begin
      if (IDX_W'(i) == touch_idx)            age_d[i] = '0;
      else if (age_q[i] < age_q[touch_idx])  age_d[i] = age_q[i] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      age_q <= age_d;
    end
  end

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    old_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!ent_valid[i]) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(i);
      end
    end
    for (int i = 0; i < N; i++) begin
      if (age_q[i] == IDX_W'(N - 1)) old_idx = IDX_W'(i);
    end
    victim_idx = have_free ? free_idx : old_idx;
  end
endmodule

// File: rtl/row_dirty_tracker.sv
module row_dirty_tracker #(
  parameter int ENTRIES      = 64,
  parameter int BLKS_PER_ROW = 64,
  parameter int BLK_ADDR_W   = 26,
  localparam int BIT_W = $clog2(BLKS_PER_ROW),
  localparam int ROW_W = BLK_ADDR_W - BIT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd_valid,
  input  logic                    upd_mark,
  input  logic [BLK_ADDR_W-1:0]   upd_addr,
  output logic                    upd_was_dirty,
  input  logic [BLK_ADDR_W-1:0]   q_blk_addr,
  output logic                    q_blk_dirty,
  input  logic [ROW_W-1:0]        q_row,
  output logic                    q_row_hit,
  output logic [BLKS_PER_ROW-1:0] q_row_vec,
  output logic                    vict_valid,
  output logic [ROW_W-1:0]        vict_row,
  output logic [BLKS_PER_ROW-1:0] vict_vec
);
  import rdt_pkg::*;

  localparam int ENT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int G     = BLKS_PER_ROW;

  // reset synchronizer: assert asynchronously, release on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // entry storage
  logic [ENTRIES-1:0]            ent_valid_q, ent_valid_d, ent_we;
  logic [ENTRIES-1:0][ROW_W-1:0] ent_row_q, ent_row_d;
  logic [ENTRIES-1:0][G-1:0]     ent_vec_q, ent_vec_d;

  // address split
  logic [ROW_W-1:0] upd_row, blk_row;
  logic [BIT_W-1:0] upd_bit, blk_bit;
  assign upd_row = upd_addr[BLK_ADDR_W-1:BIT_W];
  assign upd_bit = upd_addr[BIT_W-1:0];
  assign blk_row = q_blk_addr[BLK_ADDR_W-1:BIT_W];
  assign blk_bit = q_blk_addr[BIT_W-1:0];

  // three independent lookups on the same registered state
  logic [ENTRIES-1:0] upd_match, blk_match, rq_match;
  logic               upd_hit, blk_hit;
  logic [ENT_W-1:0]   upd_idx, blk_idx, rq_idx;
  logic [G-1:0]       upd_vec, blk_vec;

  rdt_row_cam #(.N(ENTRIES), .ROW_W(ROW_W), .VEC_W(G), .IDX_W(ENT_W)) u_cam_upd (
    .ent_valid(ent_valid_q), .ent_row(ent_row_q), .ent_vec(ent_vec_q), .key(upd_row),
    .match(upd_match), .hit(upd_hit), .idx(upd_idx), .vec(upd_vec));

  rdt_row_cam #(.N(ENTRIES), .ROW_W(ROW_W), .VEC_W(G), .IDX_W(ENT_W)) u_cam_blk (
    .ent_valid(ent_valid_q), .ent_row(ent_row_q), .ent_vec(ent_vec_q), .key(blk_row),
    .match(blk_match), .hit(blk_hit), .idx(blk_idx), .vec(blk_vec));

  rdt_row_cam #(.N(ENTRIES), .ROW_W(ROW_W), .VEC_W(G), .IDX_W(ENT_W)) u_cam_row (
    .ent_valid(ent_valid_q), .ent_row(ent_row_q), .ent_vec(ent_vec_q), .key(q_row),
    .match(rq_match), .hit(q_row_hit), .idx(rq_idx), .vec(q_row_vec));

  assign q_blk_dirty   = blk_hit & blk_vec[blk_bit];
  assign upd_was_dirty = upd_valid & upd_hit & upd_vec[upd_bit];

  // replacement order
  logic             touch_en;
  logic [ENT_W-1:0] touch_idx, victim_idx;

  rdt_recency #(.N(ENTRIES), .IDX_W(ENT_W)) u_recency (
    .clk(clk), .rst_n(rst_sync_n), .touch_en(touch_en), .touch_idx(touch_idx),
    .ent_valid(ent_valid_q), .victim_idx(victim_idx));

  // next state
  upd_op_e          upd_op;
  logic [G-1:0]     bit_mask;
  logic             vict_valid_d;
  logic [ROW_W-1:0] vict_row_d;
  logic [G-1:0]     vict_vec_d;

  assign upd_op   = upd_op_e'(upd_mark);
  assign bit_mask = G'(1) << upd_bit;

  always_comb begin
    ent_we       = '0;
    ent_valid_d  = ent_valid_q;
    ent_row_d    = ent_row_q;
    ent_vec_d    = ent_vec_q;
    touch_en     = 1'b0;
    touch_idx    = upd_idx;
    vict_valid_d = 1'b0;
    vict_row_d   = ent_row_q[victim_idx];
    vict_vec_d   = ent_vec_q[victim_idx];
    if (upd_valid) begin
      if (upd_op == UPD_MARK) begin
        touch_en = 1'b1;
        if (upd_hit) begin
          ent_we[upd_idx]    = 1'b1;
          ent_vec_d[upd_idx] = ent_vec_q[upd_idx] | bit_mask;
        end else begin
          touch_idx                = victim_idx;
          vict_valid_d             = ent_valid_q[victim_idx];
          ent_we[victim_idx]       = 1'b1;
          ent_valid_d[victim_idx]  = 1'b1;
          ent_row_d[victim_idx]    = upd_row;
          ent_vec_d[victim_idx]    = bit_mask;
        end
      end else if (upd_hit) begin
        ent_we[upd_idx]    = 1'b1;
        ent_vec_d[upd_idx] = ent_vec_q[upd_idx] & ~bit_mask;
        if (ent_vec_d[upd_idx] == '0) ent_valid_d[upd_idx] = 1'b0;
      end
    end
  end

  // registers
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)   ent_valid_q[i] <= 1'b0;
      else if (ent_we[i]) ent_valid_q[i] <= ent_valid_d[i];
    end
    always_ff @(posedge clk) begin
      if (ent_we[i]) begin
        ent_row_q[i] <= ent_row_d[i];
        ent_vec_q[i] <= ent_vec_d[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) vict_valid <= 1'b0;
    else             vict_valid <= vict_valid_d;
  end

  always_ff @(posedge clk) begin
    if (vict_valid_d) begin
      vict_row <= vict_row_d;
      vict_vec <= vict_vec_d;
    end
  end
endmodule

// File: rtl/rdt_tracker_chk.sv
module rdt_tracker_chk #(
  parameter int ENTRIES      = 64,
  parameter int BLKS_PER_ROW = 64,
  parameter int BLK_ADDR_W   = 26
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    upd_valid,
  input logic                    upd_mark,
  input logic [BLK_ADDR_W-1:0]   upd_addr,
  input logic                    upd_was_dirty,
  input logic [BLK_ADDR_W-1:0]   q_blk_addr,
  input logic                    q_blk_dirty,
  input logic                    q_row_hit,
  input logic [BLKS_PER_ROW-1:0] q_row_vec,
  input logic                    vict_valid,
  input logic [BLKS_PER_ROW-1:0] vict_vec,
  input logic [ENTRIES-1:0]      ent_valid,
  input logic [ENTRIES-1:0]      upd_match
);
  // R1
  single_row_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_match));

  // R3
  mark_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_mark) |=> ((q_blk_addr != $past(upd_addr)) || q_blk_dirty));

  // R5
  clear_drops_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_mark) |=> ((q_blk_addr != $past(upd_addr)) || !q_blk_dirty));

  // R5
  was_dirty_needs_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_was_dirty |-> upd_valid);

  // R6
  victim_after_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vict_valid |-> $past(upd_valid && upd_mark));

  // R6
  victim_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vict_valid |-> (vict_vec != '0));

  // R7
  victim_only_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vict_valid |-> $past(&ent_valid));

  // R9
  row_hit_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_row_hit |-> (q_row_vec != '0));
endmodule

bind row_dirty_tracker rdt_tracker_chk #(
  .ENTRIES(ENTRIES), .BLKS_PER_ROW(BLKS_PER_ROW), .BLK_ADDR_W(BLK_ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .upd_valid(upd_valid), .upd_mark(upd_mark),
  .upd_addr(upd_addr), .upd_was_dirty(upd_was_dirty), .q_blk_addr(q_blk_addr),
  .q_blk_dirty(q_blk_dirty), .q_row_hit(q_row_hit), .q_row_vec(q_row_vec),
  .vict_valid(vict_valid), .vict_vec(vict_vec), .ent_valid(ent_valid_q),
  .upd_match(upd_match)
);

// File: tb/row_dirty_tracker_tb_top.sv
module row_dirty_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int G  = 8;
  localparam int AW = 10;
  localparam int RW = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          upd_valid, upd_mark, upd_was_dirty;
  logic [AW-1:0] upd_addr, q_blk_addr;
  logic          q_blk_dirty, q_row_hit, vict_valid;
  logic [RW-1:0] q_row, vict_row;
  logic [G-1:0]  q_row_vec, vict_vec;

  int n_chk = 0;
  int n_err = 0;
  logic was_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  row_dirty_tracker #(.ENTRIES(N), .BLKS_PER_ROW(G), .BLK_ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_mark(upd_mark),
    .upd_addr(upd_addr), .upd_was_dirty(upd_was_dirty), .q_blk_addr(q_blk_addr),
    .q_blk_dirty(q_blk_dirty), .q_row(q_row), .q_row_hit(q_row_hit),
    .q_row_vec(q_row_vec), .vict_valid(vict_valid), .vict_row(vict_row),
    .vict_vec(vict_vec));

  function automatic logic [AW-1:0] ba(input int row, input int blk);
    return {RW'(row), 3'(blk)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; upd_valid = 1'b0; upd_mark = 1'b0; upd_addr = '0;
    q_blk_addr = '0; q_row = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic v, input logic mk, input logic [AW-1:0] a);
    upd_valid = v; upd_mark = mk; upd_addr = a; q_blk_addr = a;
    #1 was_q = upd_was_dirty;
    @(posedge clk);
    #1 upd_valid = 1'b0;
    @(negedge clk);
  endtask

  // {mark, addr, expected dirty before update}; row 1 = addr 8..15, row 2 = 16..23
  localparam logic [AW+1:0] VECS [9] = '{
    {1'b1, 10'd10, 1'b0},
    {1'b1, 10'd10, 1'b1},
    {1'b1, 10'd13, 1'b0},
    {1'b0, 10'd10, 1'b1},
    {1'b0, 10'd10, 1'b0},
    {1'b0, 10'd16, 1'b0},
    {1'b1, 10'd16, 1'b0},
    {1'b0, 10'd13, 1'b1},
    {1'b1, 10'd13, 1'b0}
  };

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R11 reset state
    q_blk_addr = ba(1, 2); q_row = 7'd1; #1;
    check("R11 blk clean", 32'(q_blk_dirty), 0);
    check("R11 row miss", 32'(q_row_hit), 0);
    check("R11 no victim", 32'(vict_valid), 0);
    @(negedge clk);

    // R3 R4 R5 vector walk
    for (int k = 0; k < 9; k++) begin
      step(1'b1, VECS[k][AW+1], VECS[k][AW:1]);
      check("R5 was_dirty", 32'(was_q), 32'(VECS[k][0]));
      check(VECS[k][AW+1] ? "R3 bit set" : "R5 bit cleared", 32'(q_blk_dirty), 32'(VECS[k][AW+1]));
    end
    // state: row1 {5}, row2 {0}
    q_row = 7'd1; #1;
    check("R2 row1 hit", 32'(q_row_hit), 1);
    check("R4 row1 vec", 32'(q_row_vec), 32'h20);
    q_row = 7'd2; #1;
    check("R2 row2 vec", 32'(q_row_vec), 32'h01);
    q_row = 7'd5; #1;
    check("R2 absent hit", 32'(q_row_hit), 0);
    check("R2 absent vec", 32'(q_row_vec), 0);
    q_blk_addr = ba(1, 4); #1;
    check("R1 present row bit clear", 32'(q_blk_dirty), 0);
    q_blk_addr = ba(5, 4); #1;
    check("R1 absent row clean", 32'(q_blk_dirty), 0);
    @(negedge clk);
    // R3: existing bits kept
    step(1'b1, 1'b1, ba(1, 7));
    q_row = 7'd1; #1;
    check("R3 bits kept", 32'(q_row_vec), 32'hA0);
    @(negedge clk);
    // R9 clear last bit invalidates
    step(1'b1, 1'b0, ba(2, 0));
    q_row = 7'd2; #1;
    check("R9 entry invalidated", 32'(q_row_hit), 0);
    @(negedge clk);
    // R10 same-cycle query sees old state
    upd_valid = 1'b1; upd_mark = 1'b1; upd_addr = ba(5, 0);
    q_blk_addr = ba(5, 0); q_row = 7'd5; #1;
    check("R10 blk old", 32'(q_blk_dirty), 0);
    check("R10 row old", 32'(q_row_hit), 0);
    @(posedge clk); #1 upd_valid = 1'b0;
    check("R10 blk new", 32'(q_blk_dirty), 1);
    @(negedge clk);

    // R6 R7 R8 replacement
    do_reset();
    step(1'b1, 1'b1, ba(10, 1)); check("R7 no victim 1", 32'(vict_valid), 0);
    step(1'b1, 1'b1, ba(11, 2)); check("R7 no victim 2", 32'(vict_valid), 0);
    step(1'b1, 1'b1, ba(11, 3));
    step(1'b1, 1'b1, ba(12, 4)); check("R7 no victim 3", 32'(vict_valid), 0);
    step(1'b1, 1'b1, ba(13, 5)); check("R7 no victim 4", 32'(vict_valid), 0);
    step(1'b1, 1'b1, ba(10, 6));              // refresh row 10
    step(1'b1, 1'b1, ba(14, 0));
    check("R6 victim valid", 32'(vict_valid), 1);
    check("R8 victim row lru", 32'(vict_row), 11);
    check("R6 victim vec", 32'(vict_vec), 32'h0C);
    q_row = 7'd11; #1;
    check("R6 displaced row gone", 32'(q_row_hit), 0);
    q_row = 7'd14; #1;
    check("R4 new entry vec", 32'(q_row_vec), 32'h01);
    @(negedge clk);
    check("R6 victim one cycle", 32'(vict_valid), 0);
    step(1'b1, 1'b1, ba(15, 0));
    check("R8 second victim valid", 32'(vict_valid), 1);
    check("R8 second victim row", 32'(vict_row), 12);
    check("R6 second victim vec", 32'(vict_vec), 32'h10);
    // R7 freed slot used before any eviction
    step(1'b1, 1'b0, ba(13, 5));
    step(1'b1, 1'b1, ba(20, 0));
    check("R7 free slot first", 32'(vict_valid), 0);
    q_row = 7'd10; #1;
    check("R7 lru row kept", 32'(q_row_hit), 1);
    // R5 clear of absent row has no effect
    @(negedge clk);
    step(1'b1, 1'b0, ba(30, 1));
    check("R5 absent clear was", 32'(was_q), 0);
    q_row = 7'd10; #1;
    check("R5 absent clear keeps row10", 32'(q_row_vec), 32'h42);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule